// File: doc/BRIEF.md
# Speculative Load Fault Tracker

This block sits beside the load pipeline of a core that supports speculative loads, which do not trap. Each cycle that a load is presented, the block forms the effective address from a base register value plus either an index register value or an immediate. It then checks the address and the destination register number against the alignment that the access size demands. Faults are not raised. Each one is recorded as a poison flag on the destination register, held in one flag bank for integer registers and a second bank for float registers. Poison also propagates: a fault-free load whose source registers are already poisoned passes the poison on to its destination and is told not to run.

When error logging is switched on, every checked load also claims a status record slot and a matching address slot. The record holds the destination register, the size, the slot number, the register class and two cause fields. If logging is on and no slot is free, an overflow error is raised. The perform-load verdict and the overflow error are combinational from the request. Flag and record updates take effect at the next rising clock edge. Two read ports let the surrounding pipeline inspect a flag and a record.

Top module: `nel_tracker`

## Requirements
- R1: Size code `ld_size` is 0 for byte, 1 for halfword, 2 for word, 3 for doubleword and 4 for quadword, and codes 5 to 7 behave like byte. The address is base plus index value when `use_index` is 1, and base plus immediate otherwise. A byte access never faults on alignment. Halfword faults when address bit 0 is set, word when bits [1:0] are nonzero, doubleword when bits [2:0] are nonzero, and quadword when bits [3:0] are nonzero.
- R2: A doubleword with an odd destination register number, or a quadword whose destination register number is not a multiple of 4, has a register-alignment fault.
- R3: On any fault, the destination flag is set in the bank chosen by `is_fp` (0 integer, 1 float), and the other bank is left unchanged.
- R4: With no fault, the destination flag takes the OR of the base register's flag and, only when `use_index` is 1, the index register's flag, both read from the selected bank before the update. `do_load` is 0 exactly when there is no fault and that OR is 1. On a fault, `do_load` is 1. With no request, `do_load` is 0.
- R5: Logging is active only when `ctl_valid` and `ctl_log_en` are both 1. With logging inactive, no record or address slot changes.
- R6: With logging active, the load takes the lowest-numbered slot below `ctl_slots` whose valid bit is clear.
- R7: A record word has these fields: bit 0 valid, bit 1 address-valid, [7:2] destination, [10:8] size code, [13:11] slot index, bit 14 float flag, [16:15] register cause, [18:17] memory cause. A new record sets bits 0 and 1 and fills every field, with the cause fields 00 unless R8 applies. The address slot stores the effective address.
- R8: A register-alignment fault puts 01 in the register cause field, and an address-alignment fault puts 01 in the memory cause field.
- R9: `ovf_err` is 1 during a request only when logging is active and no slot qualifies. In that case no record is written, but the flag update still takes place.
- R10: Each bank holds 64 flags as two 32-bit words, with registers 0 to 31 in the low word. `ne_probe_flag` returns the flag of register `ne_probe_idx` in the bank chosen by `ne_probe_fp`. Reset clears every flag, every record and every address slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_vld | input | 1 | A load is presented this cycle |
| ld_size | input | 3 | Access size code |
| base_idx | input | 6 | Base register number |
| base_val | input | ADDR_W | Base register value |
| use_index | input | 1 | 1: add the index register value, 0: add the immediate |
| index_idx | input | 6 | Index register number |
| index_val | input | ADDR_W | Index register value |
| imm_val | input | ADDR_W | Immediate displacement |
| tgt_idx | input | 6 | Destination register number |
| is_fp | input | 1 | Destination register class (1 float) |
| ctl_valid | input | 1 | Logging control contents are valid |
| ctl_log_en | input | 1 | Error logging enable |
| ctl_slots | input | SCNT_W | Number of record slots in use |
| do_load | output | 1 | Perform the load |
| ovf_err | output | 1 | Logging active with no free slot |
| ne_probe_fp | input | 1 | Flag read port bank select |
| ne_probe_idx | input | 6 | Flag read port register number |
| ne_probe_flag | output | 1 | Flag read port data |
| rec_probe_sel | input | SLOT_IW | Record read port slot select |
| rec_probe_word | output | 19 | Record read port data |
| rec_probe_addr | output | ADDR_W | Address slot read port data |

## Verification
The checker assumes that request inputs stay stable for the whole cycle in which `ld_vld` is high. Under that assumption the combinational verdict, the fault decode and the source-poison signal all describe the same load. It also assumes that `ctl_slots` never exceeds the number of built slots. The bench changes inputs only on falling edges, so each request is held across a full rising edge. It keeps `ctl_slots` at or below four, and it samples combinational results one nanosecond after the inputs settle. Stored state is sampled one nanosecond after the rising edge.

// File: rtl/nel_pkg.sv
package nel_pkg;
  localparam int REG_W  = 6;
  localparam int NREG   = 64;
  localparam int SIDX_W = 3;

  localparam logic [2:0] SZ_BYTE  = 3'd0;
  localparam logic [2:0] SZ_HALF  = 3'd1;
  localparam logic [2:0] SZ_WORD  = 3'd2;
  localparam logic [2:0] SZ_DWORD = 3'd3;
  localparam logic [2:0] SZ_QUAD  = 3'd4;

  localparam logic [1:0] CAUSE_NONE     = 2'b00;
  localparam logic [1:0] CAUSE_MISALIGN = 2'b01;

  // Packed MSB first: valid ends up in bit 0.
  typedef struct packed {
    logic [1:0]        mem_cause;
    logic [1:0]        reg_cause;
    logic              fp;
    logic [SIDX_W-1:0] slot;
    logic [2:0]        size;
    logic [REG_W-1:0]  dest;
    logic              addr_ok;
    logic              valid;
  } nel_rec_t;

  localparam int REC_W = $bits(nel_rec_t);
endpackage

// File: rtl/nel_align_chk.sv
module nel_align_chk
  import nel_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  tgt,
  output logic              mis_mem,
  output logic              mis_reg
);
  always_comb begin
    mis_mem = 1'b0;
    mis_reg = 1'b0;
    case (size)
      SZ_HALF:  mis_mem = addr[0];
      SZ_WORD:  mis_mem = |addr[1:0];
      SZ_DWORD: begin
        mis_mem = |addr[2:0];
        mis_reg = tgt[0];
      end
      SZ_QUAD: begin
        mis_mem = |addr[3:0];
        mis_reg = |tgt[1:0];
      end
      default: begin
        mis_mem = 1'b0;
        mis_reg = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nel_ne_bank.sv
module nel_ne_bank
  import nel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [REG_W-1:0] rd_a_idx,
  input  logic [REG_W-1:0] rd_b_idx,
  input  logic [REG_W-1:0] rd_c_idx,
  output logic             rd_a,
  output logic             rd_b,
  output logic             rd_c
);
  localparam int NWORD  = NREG / 32;
  localparam int WSEL_W = REG_W - 5;

  logic [NWORD-1:0][31:0] word_q;
  logic [NWORD-1:0][31:0] word_d;
  logic [31:0]            bit_mask;

  assign bit_mask = 32'd1 << wr_idx[4:0];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic hit;
    assign hit       = wr_idx[REG_W-1:5] == WSEL_W'(w);
    assign word_d[w] = hit ? ((word_q[w] & ~bit_mask) | (wr_val ? bit_mask : 32'd0))
                           : word_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= word_d;
    end
  end

  assign rd_a = word_q[rd_a_idx[REG_W-1:5]][rd_a_idx[4:0]];
  assign rd_b = word_q[rd_b_idx[REG_W-1:5]][rd_b_idx[4:0]];
  assign rd_c = word_q[rd_c_idx[REG_W-1:5]][rd_c_idx[4:0]];
endmodule

// File: rtl/nel_log_slots.sv
module nel_log_slots
  import nel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NSLOT   = 4,
  parameter int SCNT_W  = $clog2(NSLOT + 1),
  parameter int SLOT_IW = $clog2(NSLOT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCNT_W-1:0]  slot_cnt,
  input  logic               alloc_en,
  input  nel_rec_t           wr_rec,
  input  logic [ADDR_W-1:0]  wr_addr,
  output logic               free_found,
  output logic [SIDX_W-1:0]  free_idx,
  input  logic [SLOT_IW-1:0] rd_sel,
  output nel_rec_t           rd_rec,
  output logic [ADDR_W-1:0]  rd_addr
);
  nel_rec_t           rec_q  [NSLOT];
  logic [ADDR_W-1:0]  addr_q [NSLOT];
  logic [SLOT_IW-1:0] free_slot;

  // Scan downward so that the lowest qualifying slot wins.
  always_comb begin
    free_found = 1'b0;
    free_slot  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if ((SCNT_W'(i) < slot_cnt) && !rec_q[i].valid) begin
        free_found = 1'b1;
        free_slot  = SLOT_IW'(i);
      end
    end
  end

  assign free_idx = SIDX_W'(free_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        rec_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else if (alloc_en) begin
      rec_q[free_slot]  <= wr_rec;
      addr_q[free_slot] <= wr_addr;
    end
  end

  assign rd_rec  = rec_q[rd_sel];
  assign rd_addr = addr_q[rd_sel];
endmodule

// File: rtl/nel_tracker.sv
module nel_tracker
  import nel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NSLOT   = 4,
  parameter int SCNT_W  = $clog2(NSLOT + 1),
  parameter int SLOT_IW = $clog2(NSLOT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_vld,
  input  logic [2:0]         ld_size,
  input  logic [5:0]         base_idx,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic               use_index,
  input  logic [5:0]         index_idx,
  input  logic [ADDR_W-1:0]  index_val,
  input  logic [ADDR_W-1:0]  imm_val,
  input  logic [5:0]         tgt_idx,
  input  logic               is_fp,
  input  logic               ctl_valid,
  input  logic               ctl_log_en,
  input  logic [SCNT_W-1:0]  ctl_slots,
  output logic               do_load,
  output logic               ovf_err,
  input  logic               ne_probe_fp,
  input  logic [5:0]         ne_probe_idx,
  output logic               ne_probe_flag,
  input  logic [SLOT_IW-1:0] rec_probe_sel,
  output logic [18:0]        rec_probe_word,
  output logic [ADDR_W-1:0]  rec_probe_addr
);
  logic [ADDR_W-1:0] eff_addr;
  logic              mis_mem, mis_reg, fault;
  logic [1:0]        src_a, src_b, prb;
  logic              ne_src, ne_wr_val;
  logic              log_on, free_found, alloc_en;
  logic [SIDX_W-1:0] free_idx;
  nel_rec_t          new_rec, rd_rec;

  assign eff_addr = base_val + (use_index ? index_val : imm_val);

  nel_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .size    (ld_size),
    .addr    (eff_addr),
    .tgt     (tgt_idx),
    .mis_mem (mis_mem),
    .mis_reg (mis_reg)
  );

  assign fault = mis_mem | mis_reg;

  // Bank 0 holds integer flags, bank 1 float flags.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic bank_we;
    assign bank_we = ld_vld && (is_fp == b[0]);
    nel_ne_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_we),
      .wr_idx   (tgt_idx),
      .wr_val   (ne_wr_val),
      .rd_a_idx (base_idx),
      .rd_b_idx (index_idx),
      .rd_c_idx (ne_probe_idx),
      .rd_a     (src_a[b]),
      .rd_b     (src_b[b]),
      .rd_c     (prb[b])
    );
  end

  assign ne_src    = src_a[is_fp] | (use_index & src_b[is_fp]);
  assign ne_wr_val = fault | ne_src;
  assign do_load   = ld_vld && (fault || !ne_src);

  assign log_on   = ctl_valid && ctl_log_en;
  assign alloc_en = ld_vld && log_on && free_found;
  assign ovf_err  = ld_vld && log_on && !free_found;

  always_comb begin
    new_rec           = '0;
    new_rec.valid     = 1'b1;
    new_rec.addr_ok   = 1'b1;
    new_rec.dest      = tgt_idx;
    new_rec.size      = ld_size;
    new_rec.slot      = free_idx;
    new_rec.fp        = is_fp;
    new_rec.reg_cause = mis_reg ? CAUSE_MISALIGN : CAUSE_NONE;
    new_rec.mem_cause = mis_mem ? CAUSE_MISALIGN : CAUSE_NONE;
  end

  nel_log_slots #(
    .ADDR_W  (ADDR_W),
    .NSLOT   (NSLOT),
    .SCNT_W  (SCNT_W),
    .SLOT_IW (SLOT_IW)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_cnt   (ctl_slots),
    .alloc_en   (alloc_en),
    .wr_rec     (new_rec),
    .wr_addr    (eff_addr),
    .free_found (free_found),
    .free_idx   (free_idx),
    .rd_sel     (rec_probe_sel),
    .rd_rec     (rd_rec),
    .rd_addr    (rec_probe_addr)
  );

  assign rec_probe_word = rd_rec;
  assign ne_probe_flag  = prb[ne_probe_fp];
endmodule

// File: rtl/nel_chk.sv
module nel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_vld,
  input logic [2:0] ld_size,
  input logic       ctl_valid,
  input logic       ctl_log_en,
  input logic       do_load,
  input logic       ovf_err,
  input logic       mis_mem,
  input logic       mis_reg,
  input logic       ne_src
);
  // R1: byte-sized access never reports an address fault
  assert_byte_no_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_size == 3'd0) |-> !mis_mem);

  // R4: any fault still lets the load run
  assert_fault_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && (mis_mem || mis_reg)) |-> do_load);

  // R4: poisoned sources with no fault suppress the load
  assert_poison_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && !mis_mem && !mis_reg && ne_src) |-> !do_load);

  // R4: no verdict without a request
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |-> !do_load);

  // R9: overflow only while a request arrives with logging active
  assert_ovf_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> (ld_vld && ctl_valid && ctl_log_en));
endmodule

bind nel_tracker nel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_vld     (ld_vld),
  .ld_size    (ld_size),
  .ctl_valid  (ctl_valid),
  .ctl_log_en (ctl_log_en),
  .do_load    (do_load),
  .ovf_err    (ovf_err),
  .mis_mem    (mis_mem),
  .mis_reg    (mis_reg),
  .ne_src     (ne_src)
);

// File: tb/sim_nel_tracker.sv
`timescale 1ns/1ps
module sim_nel_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_vld, use_index, is_fp, ctl_valid, ctl_log_en;
  logic [2:0]  ld_size, ctl_slots;
  logic [5:0]  base_idx, index_idx, tgt_idx, ne_probe_idx;
  logic [31:0] base_val, index_val, imm_val, rec_probe_addr;
  logic        do_load, ovf_err, ne_probe_fp, ne_probe_flag;
  logic [1:0]  rec_probe_sel;
  logic [18:0] rec_probe_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic got_do, got_ovf;

  always #4 clk = ~clk;

  nel_tracker u0 (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] sz, input logic [5:0] b_i, input logic [31:0] b_v,
                       input logic ux, input logic [5:0] x_i, input logic [31:0] x_v,
                       input logic [31:0] imm, input logic [5:0] tgt, input logic fp);
    @(negedge clk);
    ld_size = sz; base_idx = b_i; base_val = b_v; use_index = ux;
    index_idx = x_i; index_val = x_v; imm_val = imm; tgt_idx = tgt; is_fp = fp;
    ld_vld = 1'b1;
    #1;
    got_do = do_load;
    got_ovf = ovf_err;
    @(posedge clk);
    #1;
    ld_vld = 1'b0;
  endtask

  task automatic flag_is(input string tag, input logic fp, input logic [5:0] idx, input logic exp);
    ne_probe_fp = fp; ne_probe_idx = idx;
    #1;
    check(tag, {31'd0, ne_probe_flag}, {31'd0, exp});
  endtask

  task automatic rec_is(input string tag, input logic [1:0] sel, input logic [18:0] exp_w,
                        input logic [31:0] exp_a);
    rec_probe_sel = sel;
    #1;
    check(tag, {13'd0, rec_probe_word}, {13'd0, exp_w});
    check(tag, rec_probe_addr, exp_a);
  endtask

  function automatic logic [18:0] mk_rec(input logic [5:0] dest, input logic [2:0] sz,
                                         input logic [2:0] slot, input logic fp,
                                         input logic [1:0] rc, input logic [1:0] mc);
    return {mc, rc, fp, slot, sz, dest, 1'b1, 1'b1};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; ld_vld = 1'b0; use_index = 0; is_fp = 0; ctl_valid = 0; ctl_log_en = 0;
    ctl_slots = 3'd4; ld_size = 0; base_idx = 0; index_idx = 0; tgt_idx = 0;
    base_val = 0; index_val = 0; imm_val = 0; ne_probe_fp = 0; ne_probe_idx = 0; rec_probe_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R4 idle do_load", {31'd0, do_load}, 32'd0);
    check("R9 idle ovf", {31'd0, ovf_err}, 32'd0);
    flag_is("R10 reset gr0", 0, 6'd0, 0);
    flag_is("R10 reset fr63", 1, 6'd63, 0);
    rec_is("R10 reset rec0", 2'd0, 19'd0, 32'd0);
  endtask

  task automatic t_no_log();
    ctl_valid = 0; ctl_log_en = 1;
    issue(3'd2, 6'd0, 32'h100, 0, 6'd0, 0, 32'h2, 6'd5, 0);
    check("R4 fault runs", {31'd0, got_do}, 32'd1);
    flag_is("R3 int flag set", 0, 6'd5, 1);
    flag_is("R3 fp bank untouched", 1, 6'd5, 0);
    rec_is("R5 invalid ctl no record", 2'd0, 19'd0, 32'd0);
    ctl_valid = 1; ctl_log_en = 0;
    issue(3'd2, 6'd0, 32'h100, 0, 6'd0, 0, 32'h1, 6'd9, 0);
    rec_is("R5 log disabled no record", 2'd0, 19'd0, 32'd0);
    ctl_valid = 0;
  endtask

  task automatic t_align();
    issue(3'd0, 6'd0, 32'h103, 0, 0, 0, 0, 6'd6, 0);
    check("R1 byte runs", {31'd0, got_do}, 32'd1);
    flag_is("R1 byte odd ok", 0, 6'd6, 0);
    issue(3'd1, 6'd0, 32'h101, 0, 0, 0, 0, 6'd10, 0);
    flag_is("R1 half odd faults", 0, 6'd10, 1);
    issue(3'd1, 6'd0, 32'h102, 0, 0, 0, 0, 6'd11, 0);
    flag_is("R1 half even ok", 0, 6'd11, 0);
    issue(3'd2, 6'd0, 32'h104, 0, 0, 0, 0, 6'd12, 0);
    flag_is("R1 word aligned ok", 0, 6'd12, 0);
    issue(3'd3, 6'd0, 32'h104, 0, 0, 0, 0, 6'd14, 0);
    flag_is("R1 dword addr fault", 0, 6'd14, 1);
    issue(3'd3, 6'd0, 32'h108, 0, 0, 0, 0, 6'd14, 0);
    flag_is("R1 dword aligned clears", 0, 6'd14, 0);
    issue(3'd3, 6'd0, 32'h108, 0, 0, 0, 0, 6'd15, 0);
    flag_is("R2 dword odd reg", 0, 6'd15, 1);
    issue(3'd4, 6'd0, 32'h108, 0, 0, 0, 0, 6'd16, 0);
    flag_is("R1 quad addr fault", 0, 6'd16, 1);
    issue(3'd4, 6'd0, 32'h110, 0, 0, 0, 0, 6'd18, 0);
    flag_is("R2 quad reg fault", 0, 6'd18, 1);
    issue(3'd4, 6'd0, 32'h110, 0, 0, 0, 0, 6'd20, 0);
    flag_is("R2 quad reg ok", 0, 6'd20, 0);
    issue(3'd4, 6'd0, 32'h110, 0, 0, 0, 0, 6'd16, 0);
    flag_is("R1 quad aligned clears", 0, 6'd16, 0);
  endtask

  task automatic t_prop();
    issue(3'd2, 6'd5, 32'h200, 0, 0, 0, 0, 6'd7, 0);
    check("R4 poisoned base blocks", {31'd0, got_do}, 32'd0);
    flag_is("R4 poison passes", 0, 6'd7, 1);
    issue(3'd2, 6'd0, 32'h200, 1, 6'd7, 32'h10, 0, 6'd40, 0);
    check("R4 poisoned index blocks", {31'd0, got_do}, 32'd0);
    flag_is("R10 high word flag", 0, 6'd40, 1);
    flag_is("R10 low word untouched", 0, 6'd8, 0);
    issue(3'd2, 6'd0, 32'h200, 0, 6'd7, 32'h10, 0, 6'd41, 0);
    check("R4 unused index ignored", {31'd0, got_do}, 32'd1);
    flag_is("R4 unused index no poison", 0, 6'd41, 0);
    issue(3'd2, 6'd5, 32'h200, 0, 0, 0, 0, 6'd5, 1);
    check("R4 other bank source", {31'd0, got_do}, 32'd1);
    flag_is("R3 fp flag stays clear", 1, 6'd5, 0);
    issue(3'd2, 6'd5, 32'h201, 0, 0, 0, 0, 6'd42, 0);
    check("R4 fault beats poison", {31'd0, got_do}, 32'd1);
    flag_is("R3 fault with poison", 0, 6'd42, 1);
    issue(3'd2, 6'd0, 32'h200, 0, 0, 0, 0, 6'd7, 0);
    flag_is("R4 clean load clears", 0, 6'd7, 0);
  endtask

  task automatic t_log();
    ctl_valid = 1; ctl_log_en = 1; ctl_slots = 3'd4;
    issue(3'd2, 6'd0, 32'h1000, 1, 6'd0, 32'h6, 32'h40, 6'd21, 0);
    check("R9 no ovf", {31'd0, got_ovf}, 32'd0);
    rec_is("R7 R8 mem cause rec0", 2'd0, mk_rec(6'd21, 3'd2, 3'd0, 0, 2'b00, 2'b01), 32'h1006);
    issue(3'd3, 6'd0, 32'h2000, 0, 6'd0, 32'h5, 32'h8, 6'd3, 1);
    rec_is("R6 R8 reg cause rec1", 2'd1, mk_rec(6'd3, 3'd3, 3'd1, 1, 2'b01, 2'b00), 32'h2008);
    ctl_slots = 3'd2;
    issue(3'd2, 6'd0, 32'h3000, 0, 0, 0, 0, 6'd22, 0);
    check("R9 overflow raised", {31'd0, got_ovf}, 32'd1);
    check("R9 overflow load runs", {31'd0, got_do}, 32'd1);
    rec_is("R9 overflow no record", 2'd2, 19'd0, 32'd0);
    ctl_slots = 3'd4;
    issue(3'd0, 6'd0, 32'h3001, 0, 0, 0, 0, 6'd23, 0);
    check("R6 slot free", {31'd0, got_ovf}, 32'd0);
    rec_is("R6 R7 next slot", 2'd2, mk_rec(6'd23, 3'd0, 3'd2, 0, 2'b00, 2'b00), 32'h3001);
    issue(3'd1, 6'd0, 32'h3003, 0, 0, 0, 0, 6'd24, 0);
    rec_is("R6 last slot", 2'd3, mk_rec(6'd24, 3'd1, 3'd3, 0, 2'b00, 2'b01), 32'h3003);
    issue(3'd0, 6'd0, 32'h4000, 0, 0, 0, 0, 6'd25, 0);
    check("R9 all slots full", {31'd0, got_ovf}, 32'd1);
    rec_is("R6 rec0 kept", 2'd0, mk_rec(6'd21, 3'd2, 3'd0, 0, 2'b00, 2'b01), 32'h1006);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_log();
    t_align();
    t_prop();
    t_log();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule